// File: doc/BRIEF.md
# Memory region access filter

This block decides whether a memory transaction may proceed. It compares each transaction against eight programmable protected address regions and reports the result. A transaction carries an address, a read/write flag and an agent-class code. A region that covers the address and lacks permission for that agent in that direction denies the transaction. A deny does not produce an error response. Instead the block raises a system-reset request and keeps a frozen record of the first offending access.

Each region holds the following fields:
- a base page and a limit page, both at 1 KiB granularity;
- a read-permission mask with one bit per agent class;
- a write-permission mask with one bit per agent class;
- an enable bit;
- a sticky lock bit.

A small register port stands in for the configuration mailbox. Software uses it to tear down and reprogram unlocked regions. Locked regions keep their settings until a hardware reset.

All DMA-capable peripherals reach memory tagged as virtual channel 0. Clearing that agent's write bit in a region therefore fences the region against DMA writes.

Top module: `mem_region_filter`

## Requirements
- R1: Eight regions are programmable through `cfg_addr = {region[2:0], field[1:0]}`. The fields are:
  - 0: base page, held in `cfg_wdata[21:0]`, equal to `addr[31:10]`.
  - 1: limit page, in the same bit positions.
  - 2: permissions. The read mask is in bits [6:0] and the write mask is in bits [22:16].
  - 3: control. Bit 0 is enable and bit 1 is lock.

  `cfg_rdata` returns the addressed register one clock after `cfg_addr` is presented. Bits outside these fields read as zero, and a write to one region leaves the others unchanged.
- R2: A region matches only when it is enabled and `base <= addr[31:10] <= limit`. Address bits [9:0] play no part in the match, and a disabled region never matches.
- R3: Agent codes are: 0 SRAM flush, 1 CPU snoop, 2 CPU secure mode, 3 CPU normal mode, 4 resource manager, 5 virtual channel 0, 6 virtual channel 1. A read is checked against the read-mask bit for the agent, and a write against the write-mask bit. Code 7 has no permission bit and is denied in any matching region.
- R4: A transaction is denied if any matching region denies it. An address that matches no region is always allowed.
- R5: Writing 1 to control bit 1 locks a region. While a region is locked, writes to any of its four registers are ignored. The lock is cleared only by `rst`.
- R6: A denied transaction drives `resp_allow` low. In the same cycle it raises `sys_reset_req`, which then stays high until `rst`.
- R7: The first denied transaction is recorded in `viol_addr`, `viol_agent` and `viol_write`, and `viol_valid` is set. The record does not change on later violations until `rst`.
- R8: `resp_valid` and `resp_allow` appear one clock after `txn_valid` is sampled. `resp_valid` is low in any cycle that follows an idle one.
- R9: After `rst` the following hold:
  - every region is disabled and unlocked, with all fields zero;
  - `resp_valid`, `sys_reset_req` and `viol_valid` are low;
  - every transaction is allowed.
- R10: A region whose read mask includes agent 5 but whose write mask omits it allows agent 5 reads and denies agent 5 writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Region index and field select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered readback of the addressed register |
| txn_valid | input | 1 | Transaction present |
| txn_addr | input | 32 | Transaction byte address |
| txn_write | input | 1 | 1 for a write, 0 for a read |
| txn_agent | input | 3 | Agent-class code |
| resp_valid | output | 1 | Decision valid |
| resp_allow | output | 1 | 1 when the transaction is allowed |
| sys_reset_req | output | 1 | Sticky system-reset request |
| viol_valid | output | 1 | Violation record captured |
| viol_addr | output | 32 | Address of the first violation |
| viol_agent | output | 3 | Agent of the first violation |
| viol_write | output | 1 | Direction of the first violation |

## Verification
The bench targets the following corner cases:

- **Region boundaries.** It probes the last byte below a region, its first and last bytes, and the first byte above it. An off-by-one compare would let an edge byte through, or block a byte next to the region.
- **Agent masks.** It sweeps all eight agent codes in both directions. A swapped mask or a mishandled code 7 would allow an access it should refuse.
- **Overlapping regions.** It uses a permissive region that overlaps a strict one. A design that trusted only the first hit would let writes through.
- **Locking.** It writes a locked region and then reads every field back. A design that honoured those writes, or cleared the lock on a write, would show changed fields.
- **Violation record.** It sends a second violation after the first. A design that overwrote the record would report the wrong address.

// File: rtl/mrf_pkg.sv
package mrf_pkg;

  // Field select carried in the low two bits of the configuration address
  typedef enum logic [1:0] {
    FLD_BASE  = 2'd0,
    FLD_LIMIT = 2'd1,
    FLD_PERM  = 2'd2,
    FLD_CTRL  = 2'd3
  } field_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_LOCK_BIT = 1;

  // Agent-class codes presented with each transaction
  typedef enum logic [2:0] {
    AG_SRAM_FLUSH = 3'd0,
    AG_CPU_SNOOP  = 3'd1,
    AG_CPU_SECURE = 3'd2,
    AG_CPU_NORMAL = 3'd3,
    AG_RES_MGR    = 3'd4,
    AG_VC0        = 3'd5,
    AG_VC1        = 3'd6
  } agent_e;

endpackage

// File: rtl/mrf_cfg_regs.sv
module mrf_cfg_regs #(
  parameter  int NUM_REGIONS = 8,
  parameter  int PAGE_W      = 22,
  parameter  int NUM_AGENTS  = 7,
  parameter  int CFG_DW      = 32,
  parameter  int WR_MASK_LSB = 16,
  localparam int IDX_W       = $clog2(NUM_REGIONS),
  localparam int CFG_AW      = IDX_W + 2
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   cfg_we,
  input  logic [CFG_AW-1:0]                      cfg_addr,
  input  logic [CFG_DW-1:0]                      cfg_wdata,
  output logic [CFG_DW-1:0]                      cfg_rdata,
  output logic [NUM_REGIONS-1:0][PAGE_W-1:0]     base_o,
  output logic [NUM_REGIONS-1:0][PAGE_W-1:0]     limit_o,
  output logic [NUM_REGIONS-1:0][NUM_AGENTS-1:0] rd_mask_o,
  output logic [NUM_REGIONS-1:0][NUM_AGENTS-1:0] wr_mask_o,
  output logic [NUM_REGIONS-1:0]                 en_o,
  output logic [NUM_REGIONS-1:0]                 lock_o
);
  import mrf_pkg::*;

  logic [IDX_W-1:0]  sel;
  field_e            fld;
  logic [CFG_DW-1:0] rd_next;
  logic              unused_wdata;

  assign sel          = cfg_addr[CFG_AW-1:2];
  assign fld          = field_e'(cfg_addr[1:0]);
  assign unused_wdata = ^cfg_wdata;

  logic [NUM_REGIONS-1:0][PAGE_W-1:0]     base_q, limit_q;
  logic [NUM_REGIONS-1:0][NUM_AGENTS-1:0] rd_q, wr_q;
  logic [NUM_REGIONS-1:0]                 en_q, lock_q;

  // One register slice per region; a set lock gates every write to it
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic wr_hit;
    assign wr_hit = cfg_we && (sel == IDX_W'(g)) && !lock_q[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
        rd_q[g]    <= '0;
        wr_q[g]    <= '0;
        en_q[g]    <= 1'b0;
        lock_q[g]  <= 1'b0;
      end else if (wr_hit) begin
        unique case (fld)
          FLD_BASE:  base_q[g]  <= cfg_wdata[PAGE_W-1:0];
          FLD_LIMIT: limit_q[g] <= cfg_wdata[PAGE_W-1:0];
          FLD_PERM: begin
            rd_q[g] <= cfg_wdata[NUM_AGENTS-1:0];
            wr_q[g] <= cfg_wdata[WR_MASK_LSB +: NUM_AGENTS];
          end
          FLD_CTRL: begin
            en_q[g]   <= cfg_wdata[CTRL_EN_BIT];
            lock_q[g] <= cfg_wdata[CTRL_LOCK_BIT];
          end
          default: ;
        endcase
      end
    end

    // R5: lock never drops and a locked region's fields never move
    a_r5_lock_holds: assert property (@(posedge clk) disable iff (rst)
      lock_q[g] |=> lock_q[g] && $stable(base_q[g]) && $stable(limit_q[g])
                    && $stable(rd_q[g]) && $stable(wr_q[g]) && $stable(en_q[g]));
  end

  always_comb begin
    rd_next = '0;
    unique case (fld)
      FLD_BASE:  rd_next[PAGE_W-1:0] = base_q[sel];
      FLD_LIMIT: rd_next[PAGE_W-1:0] = limit_q[sel];
      FLD_PERM: begin
        rd_next[NUM_AGENTS-1:0]             = rd_q[sel];
        rd_next[WR_MASK_LSB +: NUM_AGENTS]  = wr_q[sel];
      end
      FLD_CTRL: begin
        rd_next[CTRL_EN_BIT]   = en_q[sel];
        rd_next[CTRL_LOCK_BIT] = lock_q[sel];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_next;
  end

  assign base_o    = base_q;
  assign limit_o   = limit_q;
  assign rd_mask_o = rd_q;
  assign wr_mask_o = wr_q;
  assign en_o      = en_q;
  assign lock_o    = lock_q;

endmodule

// File: rtl/mrf_region_cmp.sv
module mrf_region_cmp #(
  parameter  int PAGE_W     = 22,
  parameter  int NUM_AGENTS = 7,
  parameter  int AGENT_W    = 3,
  localparam int AGENT_SPAN = 1 << AGENT_W
) (
  input  logic [PAGE_W-1:0]     page,
  input  logic [AGENT_W-1:0]    agent,
  input  logic                  is_write,
  input  logic [PAGE_W-1:0]     base,
  input  logic [PAGE_W-1:0]     limit,
  input  logic [NUM_AGENTS-1:0] rd_mask,
  input  logic [NUM_AGENTS-1:0] wr_mask,
  input  logic                  enable,
  output logic                  hit,
  output logic                  deny
);
  // Codes beyond the agent count land on zero padding and are refused
  logic [AGENT_SPAN-1:0] rd_pad, wr_pad;
  logic                  granted;

  assign rd_pad  = AGENT_SPAN'(rd_mask);
  assign wr_pad  = AGENT_SPAN'(wr_mask);
  assign granted = is_write ? wr_pad[agent] : rd_pad[agent];
  assign hit     = enable && (page >= base) && (page <= limit);
  assign deny    = hit && !granted;

endmodule

// File: rtl/mrf_viol_log.sv
module mrf_viol_log #(
  parameter int ADDR_W  = 32,
  parameter int AGENT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               evt,
  input  logic [ADDR_W-1:0]  evt_addr,
  input  logic [AGENT_W-1:0] evt_agent,
  input  logic               evt_write,
  output logic               viol_valid,
  output logic [ADDR_W-1:0]  viol_addr,
  output logic [AGENT_W-1:0] viol_agent,
  output logic               viol_write,
  output logic               sys_reset_req
);

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_valid    <= 1'b0;
      viol_addr     <= '0;
      viol_agent    <= '0;
      viol_write    <= 1'b0;
      sys_reset_req <= 1'b0;
    end else begin
      if (evt) sys_reset_req <= 1'b1;
      if (evt && !viol_valid) begin
        viol_valid <= 1'b1;
        viol_addr  <= evt_addr;
        viol_agent <= evt_agent;
        viol_write <= evt_write;
      end
    end
  end

  // R6: a violation requests reset on the next edge and the request persists
  a_r6_evt_requests_reset: assert property (@(posedge clk) disable iff (rst)
    evt |=> sys_reset_req);
  a_r6_reset_req_held: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |=> sys_reset_req);

  // R7: once captured, the record is frozen
  a_r7_record_frozen: assert property (@(posedge clk) disable iff (rst)
    viol_valid |=> viol_valid && $stable(viol_addr) && $stable(viol_agent)
                   && $stable(viol_write));

endmodule

// File: rtl/mem_region_filter.sv
module mem_region_filter #(
  parameter  int ADDR_W      = 32,
  parameter  int GRAN_LSB    = 10,
  parameter  int NUM_REGIONS = 8,
  parameter  int NUM_AGENTS  = 7,
  parameter  int AGENT_W     = 3,
  parameter  int CFG_DW      = 32,
  parameter  int WR_MASK_LSB = 16,
  localparam int PAGE_W      = ADDR_W - GRAN_LSB,
  localparam int CFG_AW      = $clog2(NUM_REGIONS) + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  output logic [CFG_DW-1:0]  cfg_rdata,
  input  logic               txn_valid,
  input  logic [ADDR_W-1:0]  txn_addr,
  input  logic               txn_write,
  input  logic [AGENT_W-1:0] txn_agent,
  output logic               resp_valid,
  output logic               resp_allow,
  output logic               sys_reset_req,
  output logic               viol_valid,
  output logic [ADDR_W-1:0]  viol_addr,
  output logic [AGENT_W-1:0] viol_agent,
  output logic               viol_write
);

  logic [NUM_REGIONS-1:0][PAGE_W-1:0]     base_w, limit_w;
  logic [NUM_REGIONS-1:0][NUM_AGENTS-1:0] rd_w, wr_w;
  logic [NUM_REGIONS-1:0]                 en_w, lock_w;
  logic [NUM_REGIONS-1:0]                 hit_vec, deny_vec;
  logic [PAGE_W-1:0]                      page;
  logic                                   any_deny, viol_evt;
  logic                                   unused_lock;

  assign page        = txn_addr[ADDR_W-1:GRAN_LSB];
  assign unused_lock = ^lock_w;

  mrf_cfg_regs #(
    .NUM_REGIONS (NUM_REGIONS),
    .PAGE_W      (PAGE_W),
    .NUM_AGENTS  (NUM_AGENTS),
    .CFG_DW      (CFG_DW),
    .WR_MASK_LSB (WR_MASK_LSB)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .base_o    (base_w),
    .limit_o   (limit_w),
    .rd_mask_o (rd_w),
    .wr_mask_o (wr_w),
    .en_o      (en_w),
    .lock_o    (lock_w)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    mrf_region_cmp #(
      .PAGE_W     (PAGE_W),
      .NUM_AGENTS (NUM_AGENTS),
      .AGENT_W    (AGENT_W)
    ) u_cmp (
      .page     (page),
      .agent    (txn_agent),
      .is_write (txn_write),
      .base     (base_w[g]),
      .limit    (limit_w[g]),
      .rd_mask  (rd_w[g]),
      .wr_mask  (wr_w[g]),
      .enable   (en_w[g]),
      .hit      (hit_vec[g]),
      .deny     (deny_vec[g])
    );
  end

  // Any single refusing region vetoes the access
  assign any_deny = |deny_vec;
  assign viol_evt = txn_valid && any_deny;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_allow <= 1'b1;
    end else begin
      resp_valid <= txn_valid;
      resp_allow <= !viol_evt;
    end
  end

  mrf_viol_log #(
    .ADDR_W  (ADDR_W),
    .AGENT_W (AGENT_W)
  ) u_log (
    .clk           (clk),
    .rst           (rst),
    .evt           (viol_evt),
    .evt_addr      (txn_addr),
    .evt_agent     (txn_agent),
    .evt_write     (txn_write),
    .viol_valid    (viol_valid),
    .viol_addr     (viol_addr),
    .viol_agent    (viol_agent),
    .viol_write    (viol_write),
    .sys_reset_req (sys_reset_req)
  );

  // R8: one decision per strobe, one cycle later
  a_r8_resp_follows: assert property (@(posedge clk) disable iff (rst)
    txn_valid |=> resp_valid);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !txn_valid |=> !resp_valid);
  // R4: an address outside every enabled region is allowed
  a_r4_no_hit_allows: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && hit_vec == '0) |=> resp_allow);
  // R6: a refusal is always accompanied by the reset request
  a_r6_deny_has_reset: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_allow) |-> sys_reset_req);

endmodule

// File: tb/mem_region_filter_bench.sv
module mem_region_filter_bench;
  import mrf_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        txn_valid = 1'b0;
  logic [31:0] txn_addr = '0;
  logic        txn_write = 1'b0;
  logic [2:0]  txn_agent = '0;
  logic        resp_valid, resp_allow, sys_reset_req, viol_valid, viol_write;
  logic [31:0] viol_addr;
  logic [2:0]  viol_agent;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  mem_region_filter u_mem_region_filter (
    .clk (clk), .rst (rst),
    .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .txn_valid (txn_valid), .txn_addr (txn_addr), .txn_write (txn_write),
    .txn_agent (txn_agent),
    .resp_valid (resp_valid), .resp_allow (resp_allow),
    .sys_reset_req (sys_reset_req),
    .viol_valid (viol_valid), .viol_addr (viol_addr),
    .viol_agent (viol_agent), .viol_write (viol_write)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cfg_write(input int region, input field_e fld, input logic [31:0] data);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = {region[2:0], fld};
    cfg_wdata = data;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic cfg_expect(input string req, input int region, input field_e fld,
                            input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = {region[2:0], fld};
    @(negedge clk);
    check(req, "readback", cfg_rdata, exp);
  endtask

  task automatic txn(input string req, input logic [31:0] addr, input logic wr,
                     input logic [2:0] agent, input logic exp_allow);
    @(negedge clk);
    txn_valid = 1'b1;
    txn_addr  = addr;
    txn_write = wr;
    txn_agent = agent;
    @(negedge clk);
    txn_valid = 1'b0;
    check(req, "resp_valid", {31'b0, resp_valid}, 32'd1);
    check(req, "resp_allow", {31'b0, resp_allow}, {31'b0, exp_allow});
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R9", "resp_valid", {31'b0, resp_valid}, 32'd0);
    check("R9", "sys_reset_req", {31'b0, sys_reset_req}, 32'd0);
    check("R9", "viol_valid", {31'b0, viol_valid}, 32'd0);
    cfg_expect("R9", 3, FLD_CTRL, 32'd0);
    cfg_expect("R9", 0, FLD_BASE, 32'd0);
    txn("R9", 32'h0000_0000, 1'b1, 3'd7, 1'b1);
    txn("R4", 32'hFFFF_FC00, 1'b0, 3'd5, 1'b1);
  endtask

  task automatic t_program_readback();
    do_reset();
    cfg_write(5, FLD_BASE, 32'h0012_3456);
    cfg_write(5, FLD_LIMIT, 32'h003F_FFFF);
    cfg_write(5, FLD_PERM, 32'hFFFF_FFFF);
    cfg_write(5, FLD_CTRL, 32'h0000_0001);
    cfg_expect("R1", 5, FLD_BASE, 32'h0012_3456);
    cfg_expect("R1", 5, FLD_LIMIT, 32'h003F_FFFF);
    cfg_expect("R1", 5, FLD_PERM, 32'h007F_007F);
    cfg_expect("R1", 5, FLD_CTRL, 32'h0000_0001);
    cfg_expect("R1", 2, FLD_BASE, 32'd0);
  endtask

  task automatic t_match_bounds();
    do_reset();
    cfg_write(0, FLD_BASE, 32'h10);
    cfg_write(0, FLD_LIMIT, 32'h13);
    cfg_write(0, FLD_PERM, 32'h007F_0000);
    cfg_write(0, FLD_CTRL, 32'h1);
    txn("R2", 32'h0000_3FFF, 1'b0, 3'd3, 1'b1);
    txn("R2", 32'h0000_4000, 1'b0, 3'd3, 1'b0);
    txn("R2", 32'h0000_4FFF, 1'b0, 3'd3, 1'b0);
    txn("R2", 32'h0000_5000, 1'b0, 3'd3, 1'b1);
    txn("R2", 32'h0000_4800, 1'b1, 3'd3, 1'b1);
    cfg_write(0, FLD_CTRL, 32'h0);
    txn("R2", 32'h0000_4000, 1'b0, 3'd3, 1'b1);
  endtask

  task automatic t_agent_masks();
    logic [6:0] rd_m;
    logic [6:0] wr_m;
    rd_m = 7'b0101010;
    wr_m = 7'b1011111;
    do_reset();
    cfg_write(1, FLD_BASE, 32'h40);
    cfg_write(1, FLD_LIMIT, 32'h7F);
    cfg_write(1, FLD_PERM, {9'b0, wr_m, 9'b0, rd_m});
    cfg_write(1, FLD_CTRL, 32'h1);
    for (int a = 0; a < 8; a++) begin
      txn("R3", 32'h0001_2000, 1'b0, a[2:0], (a < 7) ? rd_m[a] : 1'b0);
      txn("R3", 32'h0001_2000, 1'b1, a[2:0], (a < 7) ? wr_m[a] : 1'b0);
    end
    txn("R10", 32'h0001_0000, 1'b0, 3'd5, 1'b1);
    txn("R10", 32'h0001_FFFC, 1'b1, 3'd5, 1'b0);
  endtask

  task automatic t_overlap();
    do_reset();
    cfg_write(2, FLD_BASE, 32'h100);
    cfg_write(2, FLD_LIMIT, 32'h1FF);
    cfg_write(2, FLD_PERM, 32'h007F_007F);
    cfg_write(2, FLD_CTRL, 32'h1);
    cfg_write(3, FLD_BASE, 32'h180);
    cfg_write(3, FLD_LIMIT, 32'h180);
    cfg_write(3, FLD_PERM, 32'h0000_007F);
    cfg_write(3, FLD_CTRL, 32'h1);
    txn("R4", 32'h0006_0000, 1'b1, 3'd3, 1'b0);
    txn("R4", 32'h0005_FC00, 1'b1, 3'd3, 1'b1);
    txn("R4", 32'h0006_0000, 1'b0, 3'd3, 1'b1);
  endtask

  task automatic t_lock();
    do_reset();
    cfg_write(4, FLD_BASE, 32'h200);
    cfg_write(4, FLD_LIMIT, 32'h200);
    cfg_write(4, FLD_PERM, 32'h007F_007F);
    cfg_write(4, FLD_CTRL, 32'h3);
    cfg_write(4, FLD_BASE, 32'h300);
    cfg_write(4, FLD_LIMIT, 32'h3FF);
    cfg_write(4, FLD_PERM, 32'h0);
    cfg_write(4, FLD_CTRL, 32'h0);
    cfg_expect("R5", 4, FLD_BASE, 32'h200);
    cfg_expect("R5", 4, FLD_LIMIT, 32'h200);
    cfg_expect("R5", 4, FLD_PERM, 32'h007F_007F);
    cfg_expect("R5", 4, FLD_CTRL, 32'h3);
    txn("R5", 32'h0008_0000, 1'b1, 3'd5, 1'b1);
    cfg_write(7, FLD_BASE, 32'h55);
    cfg_expect("R5", 7, FLD_BASE, 32'h55);
    do_reset();
    cfg_expect("R5", 4, FLD_CTRL, 32'h0);
  endtask

  task automatic t_violation();
    do_reset();
    cfg_write(6, FLD_BASE, 32'h400);
    cfg_write(6, FLD_LIMIT, 32'h400);
    cfg_write(6, FLD_PERM, 32'h0000_007F);
    cfg_write(6, FLD_CTRL, 32'h1);
    txn("R6", 32'h0010_0010, 1'b0, 3'd2, 1'b1);
    check("R6", "no request before deny", {31'b0, sys_reset_req}, 32'd0);
    txn("R6", 32'h0010_0123, 1'b1, 3'd2, 1'b0);
    check("R6", "sys_reset_req", {31'b0, sys_reset_req}, 32'd1);
    check("R7", "viol_valid", {31'b0, viol_valid}, 32'd1);
    check("R7", "viol_addr", viol_addr, 32'h0010_0123);
    check("R7", "viol_agent", {29'b0, viol_agent}, 32'd2);
    check("R7", "viol_write", {31'b0, viol_write}, 32'd1);
    txn("R7", 32'h0010_0200, 1'b1, 3'd4, 1'b0);
    check("R7", "viol_addr kept", viol_addr, 32'h0010_0123);
    check("R7", "viol_agent kept", {29'b0, viol_agent}, 32'd2);
    repeat (3) @(negedge clk);
    check("R6", "request held", {31'b0, sys_reset_req}, 32'd1);
    do_reset();
    check("R6", "request cleared", {31'b0, sys_reset_req}, 32'd0);
    check("R7", "record cleared", {31'b0, viol_valid}, 32'd0);
  endtask

  task automatic t_timing();
    do_reset();
    @(negedge clk);
    check("R8", "idle resp_valid", {31'b0, resp_valid}, 32'd0);
    txn("R8", 32'h0000_1000, 1'b0, 3'd0, 1'b1);
    @(negedge clk);
    check("R8", "resp_valid drops", {31'b0, resp_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_program_readback();
    t_match_bounds();
    t_agent_masks();
    t_overlap();
    t_lock();
    t_violation();
    t_timing();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule